// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Read-During-Write Behaviour

This block is a synchronous memory with two full read/write ports on a single clock. Each port has its own enable, write enable, address and write data. Each port also has a registered read output, so read data appears one cycle after the address.

Each port picks, through its own parameter, what its read output shows in a cycle where that port writes. There are three choices:

- Old-data: the output shows the word as it was before the write.
- Pass-through: the output shows the data being written.
- Hold: the output keeps its earlier value.

Both ports update one shared storage array on the same edge. The block does not arbitrate when both ports reach the same address. Instead it raises a one-cycle collision flag, and in simulation it prints a note when both ports write the same word. The storage starts from contents set by two parameters, a base value and a step.

Top module: `dpr_modes`

## Requirements
- R1: An enabled port that is not writing presents the stored word at its address on its read output one clock after the address is applied.
- R2: A port in old-data mode (WM_READ_FIRST) that writes shows, one clock later, the word the address held before that write.
- R3: A port in pass-through mode (WM_WRITE_FIRST) that writes shows, one clock later, the data it wrote.
- R4: A port in hold mode (WM_NO_CHANGE) that writes leaves its read output unchanged.
- R5: A port whose enable is low neither writes nor reads, and its read output keeps its value.
- R6: Both ports share one array, so a word written through one port is read back through the other on later cycles.
- R7: The two ports' modes are set independently, so one instance may mix any two of the three modes.
- R8: `collide` is high for the single cycle after one in which both ports are enabled on the same address and at least one of them writes; otherwise it is low.
- R9: While `rst_n` is low at a clock edge, both read outputs become zero and `collide` becomes low. Reset does not alter the stored words.
- R10: Before any write, word i holds INIT_BASE + i*INIT_STEP, truncated to DATA_W bits.
- R11: When both ports write the same address in one cycle, no logic resolves the conflict. The stored word is undefined, and the simulation model prints a note.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read outputs and the collision flag |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| collide | output | 1 | One-cycle pulse after a same-address access with at least one write |

## Verification
The assertions assume that a port's write enable has meaning only while its enable is high. They also assume that a read of a word being written by the other port in the same cycle has no defined result, so the old-data and read checks relate the output to the array word sampled before the edge, not to any arbitrated value.

The stimulus is random over a narrow address window so that collisions happen often. The bench model marks a word unknown after a double write, and it marks a reader's result unknown when the other port writes its address. It skips those comparisons until a later write or reset makes the values defined again.

// File: rtl/rdw_pkg.sv
// Shared types for the dual-port RAM.
// Assumes: nothing; holds only the write-mode encoding.
package rdw_pkg;
    typedef enum logic [1:0] {
        WM_READ_FIRST  = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;
endpackage

// File: rtl/dpr_array.sv
// Storage array with two write ports and two asynchronous read taps.
// The taps show the word before the current edge's writes.
// Assumes: same-address double writes are undefined (port B happens to land last).
module dpr_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter logic [DATA_W-1:0] INIT_BASE = '0,
    parameter logic [DATA_W-1:0] INIT_STEP = '0
) (
    input  logic              clk,
    input  logic              wr_a,
    input  logic [ADDR_W-1:0] adr_a,
    input  logic [DATA_W-1:0] dat_a,
    input  logic              wr_b,
    input  logic [ADDR_W-1:0] adr_b,
    input  logic [DATA_W-1:0] dat_b,
    output logic [DATA_W-1:0] old_a,
    output logic [DATA_W-1:0] old_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Load the starting contents from the base and step parameters.
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = INIT_BASE + DATA_W'(i) * INIT_STEP;
        end
    end

    // Apply both ports' writes on the shared edge, with no arbitration.
    always_ff @(posedge clk) begin
        if (wr_a) mem[adr_a] <= dat_a;
        if (wr_b) mem[adr_b] <= dat_b;
    end

    assign old_a = mem[adr_a];
    assign old_b = mem[adr_b];
endmodule

// File: rtl/dpr_rdport.sv
// Read-output register for one port. The write mode chosen by MODE sets
// what is loaded in a write cycle.
// Assumes: old_word is the array word at the port address before the edge.
module dpr_rdport
    import rdw_pkg::*;
#(
    parameter int     DATA_W = 16,
    parameter wmode_e MODE   = WM_READ_FIRST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    generate
        if (MODE == WM_WRITE_FIRST) begin : g_wf
            // Load the written data on writes and the stored word on reads.
            always_ff @(posedge clk) begin
                if (!rst_n)  rdata <= '0;
                else if (en) rdata <= we ? wdata : old_word;
            end
            assert_wf_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
                en && we |=> rdata == $past(wdata));
        end else if (MODE == WM_NO_CHANGE) begin : g_nc
            // Load only on reads; writes leave the output alone.
            always_ff @(posedge clk) begin
                if (!rst_n)         rdata <= '0;
                else if (en && !we) rdata <= old_word;
            end
            assert_nc_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
                en && we |=> $stable(rdata));
        end else begin : g_rf
            // Load the pre-write word whenever enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)  rdata <= '0;
                else if (en) rdata <= old_word;
            end
            assert_rf_old_R2: assert property (@(posedge clk) disable iff (!rst_n)
                en && we |=> rdata == $past(old_word));
        end
    endgenerate

    assert_read_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en && !we |=> rdata == $past(old_word));
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rdata));
endmodule

// File: rtl/dpr_collide.sv
// Flags a same-address access by both ports with at least one write.
// The flag is registered so that it lines up with the read data.
// Assumes: nothing is resolved here; the flag only reports the event.
module dpr_collide #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] adr_a,
    input  logic              en_b,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] adr_b,
    output logic              hit
);
    logic same;
    assign same = en_a && en_b && (adr_a == adr_b);

    // Register the collision pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) hit <= 1'b0;
        else        hit <= same && (we_a || we_b);
    end

    // Simulation note when both ports write one word in the same cycle (R11).
    always_ff @(posedge clk) begin
        if (rst_n && same && we_a && we_b)
            $display("note: both ports wrote address %0d at %0t; word undefined", adr_a, $time);
    end

    assert_coll_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(en_a && en_b && (adr_a == adr_b)));
    assert_coll_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(we_a || we_b));
    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> !hit);
endmodule

// File: rtl/dpr_modes.sv
// Top level: dual-port single-clock RAM with a write mode set per port and
// a collision flag. The array is shared; each port has its own output register.
// Assumes: the caller avoids, or tolerates, same-address double writes.
module dpr_modes
    import rdw_pkg::*;
#(
    parameter int     ADDR_W    = 6,
    parameter int     DATA_W    = 16,
    parameter wmode_e MODE_A    = WM_READ_FIRST,
    parameter wmode_e MODE_B    = WM_WRITE_FIRST,
    parameter logic [DATA_W-1:0] INIT_BASE = 16'h1234,
    parameter logic [DATA_W-1:0] INIT_STEP = 16'h0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              collide
);
    logic [DATA_W-1:0] old_a, old_b;
    logic              wr_a, wr_b;

    assign wr_a = a_en && a_we;
    assign wr_b = b_en && b_we;

    dpr_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .INIT_BASE(INIT_BASE), .INIT_STEP(INIT_STEP)
    ) u_array (
        .clk(clk),
        .wr_a(wr_a), .adr_a(a_addr), .dat_a(a_wdata),
        .wr_b(wr_b), .adr_b(b_addr), .dat_b(b_wdata),
        .old_a(old_a), .old_b(old_b)
    );

    dpr_rdport #(.DATA_W(DATA_W), .MODE(MODE_A)) u_port_a (
        .clk(clk), .rst_n(rst_n), .en(a_en), .we(a_we),
        .old_word(old_a), .wdata(a_wdata), .rdata(a_rdata)
    );

    dpr_rdport #(.DATA_W(DATA_W), .MODE(MODE_B)) u_port_b (
        .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we),
        .old_word(old_b), .wdata(b_wdata), .rdata(b_rdata)
    );

    dpr_collide #(.ADDR_W(ADDR_W)) u_collide (
        .clk(clk), .rst_n(rst_n),
        .en_a(a_en), .we_a(a_we), .adr_a(a_addr),
        .en_b(b_en), .we_b(b_we), .adr_b(b_addr),
        .hit(collide)
    );

    assert_rst_out_R9: assert property (@(posedge clk)
        !rst_n |=> (a_rdata == '0) && (b_rdata == '0));
endmodule

// File: tb/dpr_modes_tb.sv
module dpr_modes_tb;
    import rdw_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] IBASE = 16'h1234;
    localparam logic [DW-1:0] ISTEP = 16'h0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_q1, b_q1, a_q2, b_q2;
    logic coll1, coll2;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Instance 1: A old-data, B pass-through.
    dpr_modes #(.ADDR_W(AW), .DATA_W(DW), .MODE_A(WM_READ_FIRST), .MODE_B(WM_WRITE_FIRST),
                .INIT_BASE(IBASE), .INIT_STEP(ISTEP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_q1),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_q1),
        .collide(coll1));

    // Instance 2 (R7): A hold, B old-data; same stimulus.
    dpr_modes #(.ADDR_W(AW), .DATA_W(DW), .MODE_A(WM_NO_CHANGE), .MODE_B(WM_READ_FIRST),
                .INIT_BASE(IBASE), .INIT_STEP(ISTEP)) u_dut2 (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_q2),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_q2),
        .collide(coll2));

    // Bench model.
    logic [DW-1:0] mdl [DEPTH];
    bit            vld [DEPTH];
    logic [DW-1:0] exq [4];   // index: dut*2 + port
    bit            exk [4];
    int            md  [4] = '{0, 1, 2, 0};   // 0 old-data, 1 pass-through, 2 hold
    bit            exc;

    function automatic string mtag(int mode, bit en, bit we, string ovr);
        if (ovr != "") return ovr;
        if (!en) return "R5";
        if (!we) return "R1";
        case (mode)
            0: return "R2";
            1: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: compute expectations from the model, advance, compare.
    task automatic cyc(bit ae, bit awe, logic [AW-1:0] aa, logic [DW-1:0] ad,
                       bit be, bit bwe, logic [AW-1:0] ba, logic [DW-1:0] bd, string ovr);
        bit same, xa, xb;
        string tg [4];
        a_en = ae; a_we = awe; a_addr = aa; a_wdata = ad;
        b_en = be; b_we = bwe; b_addr = ba; b_wdata = bd;
        same = ae && be && (aa == ba);
        xa = same && bwe;   // A's view of the old word is undefined
        xb = same && awe;
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 2; p++) begin
                automatic int k = d*2 + p;
                automatic bit en = p ? be : ae;
                automatic bit we = p ? bwe : awe;
                automatic logic [AW-1:0] ad_ = p ? ba : aa;
                automatic logic [DW-1:0] wd = p ? bd : ad;
                automatic bit oknown = vld[ad_] && !(p ? xb : xa);
                tg[k] = mtag(md[k], en, we, ovr);
                if (d == 1) tg[k] = {"R7/", tg[k]};
                if (en) begin
                    if (!we) begin
                        exq[k] = mdl[ad_]; exk[k] = oknown;
                    end else if (md[k] == 0) begin
                        exq[k] = mdl[ad_]; exk[k] = oknown;
                    end else if (md[k] == 1) begin
                        exq[k] = wd; exk[k] = 1'b1;
                    end
                end
            end
        end
        exc = same && (awe || bwe);
        if (ae && awe) begin mdl[aa] = ad; vld[aa] = 1'b1; end
        if (be && bwe) begin mdl[ba] = bd; vld[ba] = 1'b1; end
        if (same && awe && bwe) vld[aa] = 1'b0;   // R11: undefined word
        @(posedge clk);
        @(negedge clk);
        if (exk[0]) chk(tg[0], a_q1, exq[0]);
        if (exk[1]) chk(tg[1], b_q1, exq[1]);
        if (exk[2]) chk(tg[2], a_q2, exq[2]);
        if (exk[3]) chk(tg[3], b_q2, exq[3]);
        chk("R8", {15'd0, coll1}, {15'd0, exc});
        chk("R8", {15'd0, coll2}, {15'd0, exc});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        a_en = 1'b1; a_we = 1'b0; b_en = 1'b1; b_we = 1'b0;   // enables must not matter
        @(posedge clk);
        @(negedge clk);
        chk("R9", a_q1, '0); chk("R9", b_q1, '0);
        chk("R9", a_q2, '0); chk("R9", b_q2, '0);
        chk("R9", {15'd0, coll1}, 16'd0);
        chk("R9", {15'd0, coll2}, 16'd0);
        for (int k = 0; k < 4; k++) begin exq[k] = '0; exk[k] = 1'b1; end
        a_en = 1'b0; b_en = 1'b0;
        rst_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int i = 0; i < DEPTH; i++) begin
            mdl[i] = IBASE + DW'(i) * ISTEP;
            vld[i] = 1'b1;
        end
        @(negedge clk);
        do_reset();

        // R10: starting contents, read through both ports.
        for (int i = 0; i < 4; i++)
            cyc(1, 0, AW'(i), '0, 1, 0, AW'(DEPTH-1-i), '0, "R10");

        // R6: write through A, read back through B.
        cyc(1, 1, 6'd10, 16'hBEEF, 0, 0, '0, '0, "");
        cyc(0, 0, '0, '0, 1, 0, 6'd10, '0, "R6");
        cyc(0, 0, '0, '0, 1, 1, 6'd11, 16'hCAFE, "");
        cyc(1, 0, 6'd11, '0, 0, 0, '0, '0, "R6");

        // R5: disabled ports with write enable set must not write.
        cyc(0, 1, 6'd12, 16'h0BAD, 0, 1, 6'd13, 16'h0BAD, "R5");
        cyc(1, 0, 6'd12, '0, 1, 0, 6'd13, '0, "R5");

        // R2/R3/R4: writes on both ports at different addresses.
        cyc(1, 1, 6'd20, 16'h1111, 1, 1, 6'd21, 16'h2222, "");
        cyc(1, 1, 6'd20, 16'h3333, 1, 1, 6'd21, 16'h4444, "");

        // R8: read/write collision, then R11 double write and its rewrite.
        cyc(1, 1, 6'd30, 16'h5555, 1, 0, 6'd30, '0, "");
        cyc(1, 0, 6'd31, '0, 1, 0, 6'd31, '0, "");    // same address, no write: no flag
        cyc(1, 1, 6'd32, 16'h6666, 1, 1, 6'd32, 16'h7777, "");
        cyc(1, 1, 6'd32, 16'h8888, 0, 0, '0, '0, "");
        cyc(0, 0, '0, '0, 1, 0, 6'd32, '0, "R11");

        // Random traffic over a narrow window to provoke collisions.
        for (int n = 0; n < 3000; n++) begin
            automatic bit ae = ($urandom % 10) < 8;
            automatic bit be = ($urandom % 10) < 8;
            automatic bit aw = ($urandom % 10) < 4;
            automatic bit bw = ($urandom % 10) < 4;
            automatic logic [AW-1:0] aa = AW'($urandom % 8);
            automatic logic [AW-1:0] ba = AW'($urandom % 8);
            cyc(ae, aw, aa, DW'($urandom), be, bw, ba, DW'($urandom), "");
        end

        // R9: reset keeps the stored words.
        cyc(1, 1, 6'd40, 16'hA5A5, 0, 0, '0, '0, "");
        do_reset();
        cyc(1, 0, 6'd40, '0, 1, 0, 6'd40, '0, "R9");

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule